// File: doc/BRIEF.md
# Programmable Root Clock Generator with Fractional M/N:D Stage

This block produces one output clock from a set of source clocks. All logic runs on a single system clock. Each source is given as a one-cycle strobe `src_tick[i]`, and each strobe marks one edge of that source, either rising or falling. Two strobes therefore make one full source period.

The selected source first goes through a pre-divider that can divide by integer or half-integer ratios. After that, an optional fractional counter can be switched in. This counter takes the output ratio and duty from three programmed values: M, N and D.

Software programs the source, divider, mode, M, N and D over a small valid/write/address/data register bus. All of these writes go to shadow registers, and none of them reach the running generator on their own. To apply them, software sets bit 0 of the command register and then polls that bit. The bit reads 1 while the switch is in progress. When the new settings are in use, the hardware clears it.

During a switch the generator works in four steps:
1. It keeps the old setting running until the output is low.
2. It freezes the output low.
3. It waits for two edges of the new source.
4. It starts the new setting from the beginning of its period.

Because of this sequence, no shortened pulse appears on the output.

Top module: `rcg_root`

## Requirements
- R1: After reset, `clk_out` and `upd_busy` are 0 and every register reads 0. The generator runs from source 0 with the pre-divider field 0 and the fractional stage off.
- R2: If the pre-divider field (configuration bits [4:0]) holds a nonzero value f, the output period is f+1 source edges and the high time is floor((f+1)/2) edges. An odd f gives the integer ratio (f+1)/2, and an even f gives a half-integer ratio.
- R3: A pre-divider field of 0 gives a period of 2 source edges with 1 edge high, which is divide by 1.
- R4: The mode field (configuration bits [13:12]) turns the fractional stage on only when it holds 2. Any other value gives the plain pre-divided clock.
- R5: When the fractional stage is on, the block decodes N = M + ~Nreg and D = (~Dreg) >> 1, both modulo 2^MND_W. At each pre-divider period boundary the output becomes (acc < D), and then acc advances to (acc + M) mod N. acc restarts at 0 on every update.
- R6: An N register of 0 turns the fractional stage off even when the mode field is 2.
- R7: Writes to the configuration (address 1), M (address 2), N (address 3) and D (address 4) registers leave the output unchanged until an update is issued.
- R8: Writing address 0 with bit 0 = 1 while no update is pending sets `upd_busy` on the next cycle. The busy flag clears by itself once the new settings are in use, and reads of address 0 return it in bit 0.
- R9: Read data appears on `bus_rdata` in the cycle after the read request. Reads return the shadow values, with configuration fields at bits [13:12], [10:8] and [4:0] and all other bits 0. Addresses 5 to 7 read 0.
- R10: On an update, the old setting keeps running only while `clk_out` is high. The output then stays low while two edges of the new source pass. The new setting starts from its period origin, and `upd_busy` falls with `clk_out` low.
- R11: The source-select field (configuration bits [10:8]) chooses which `src_tick` bit drives the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NSRC | One strobe per edge of each source clock |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| upd_busy | output | 1 | Update in progress (also bit 0 of address 0) |
| clk_out | output | 1 | Generated clock level, registered |

## Verification
The bench looks for several classes of error.

- Off-by-one pre-divider decoding: a wrong decode shows up as a period one edge long or short, and a half-integer setting is the case most likely to expose it.
- Shadow leakage: a design whose shadow registers leak through would change `clk_out` before the command bit is set.
- Bad handover: a careless handover would cut a high pulse short, or let `upd_busy` drop while the output is high.
- Fractional-stage faults: a wrong inverse decode of N or D would stretch the period or the duty. An accumulator that does not step by M would spread the high pulses in the wrong pattern.

A behavioural model in the bench exposes all of these, because it predicts `clk_out` and `upd_busy` on every cycle.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  // Register layout constants (the field positions are decoded by software)
  localparam int DIV_W    = 5;
  localparam int SRC_W    = 3;
  localparam int MODE_W   = 2;
  localparam int DIV_LSB  = 0;
  localparam int SRC_LSB  = 8;
  localparam int MODE_LSB = 12;
  localparam int ADDR_W   = 3;

  localparam logic [MODE_W-1:0] MODE_FRAC = 2'd2;

  localparam logic [ADDR_W-1:0] A_CMD = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG = 3'd1;
  localparam logic [ADDR_W-1:0] A_M   = 3'd2;
  localparam logic [ADDR_W-1:0] A_N   = 3'd3;
  localparam logic [ADDR_W-1:0] A_D   = 3'd4;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [MODE_W-1:0] mode;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SYNC  = 2'd2
  } sw_state_t;
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
  import rcg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MND_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  output logic [DATA_W-1:0] bus_rdata,
  output cfg_t              sh_cfg,
  output logic [MND_W-1:0]  sh_m,
  output logic [MND_W-1:0]  sh_n,
  output logic [MND_W-1:0]  sh_d,
  output logic              upd_req
);
  logic wr_en, rd_en;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en   = bus_valid && bus_write;
  assign rd_en   = bus_valid && !bus_write;
  assign upd_req = wr_en && (bus_addr == A_CMD) && bus_wdata[0];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CMD: rd_mux[0] = busy;
      A_CFG: begin
        rd_mux[SRC_LSB  +: SRC_W]  = sh_cfg.src;
        rd_mux[MODE_LSB +: MODE_W] = sh_cfg.mode;
        rd_mux[DIV_LSB  +: DIV_W]  = sh_cfg.div;
      end
      A_M:     rd_mux[MND_W-1:0] = sh_m;
      A_N:     rd_mux[MND_W-1:0] = sh_n;
      A_D:     rd_mux[MND_W-1:0] = sh_d;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cfg    <= '0;
      sh_m      <= '0;
      sh_n      <= '0;
      sh_d      <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_en) begin
        case (bus_addr)
          A_CFG: begin
            sh_cfg.src  <= bus_wdata[SRC_LSB  +: SRC_W];
            sh_cfg.mode <= bus_wdata[MODE_LSB +: MODE_W];
            sh_cfg.div  <= bus_wdata[DIV_LSB  +: DIV_W];
          end
          A_M:     sh_m <= bus_wdata[MND_W-1:0];
          A_N:     sh_n <= bus_wdata[MND_W-1:0];
          A_D:     sh_d <= bus_wdata[MND_W-1:0];
          default: ;
        endcase
      end
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rcg_switch_ctrl.sv
module rcg_switch_ctrl
  import rcg_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_tick,
  input  cfg_t             sh_cfg,
  input  logic [MND_W-1:0] sh_m,
  input  logic [MND_W-1:0] sh_n,
  input  logic [MND_W-1:0] sh_d,
  input  logic             upd_req,
  input  logic             out_level,
  output cfg_t             act_cfg,
  output logic [MND_W-1:0] act_m,
  output logic [MND_W-1:0] act_n,
  output logic [MND_W-1:0] act_d,
  output logic             gen_tick,
  output logic             load,
  output logic             busy
);
  sw_state_t state_q;
  logic      edge_seen_q;
  logic      old_tick, new_tick;

  // Pick one strobe out of the source bus; out-of-range selections never tick
  function automatic logic pick(input logic [NSRC-1:0] t, input logic [SRC_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (idx == SRC_W'(i)) r = t[i];
    end
    return r;
  endfunction

  assign old_tick = pick(src_tick, act_cfg.src);
  assign new_tick = pick(src_tick, sh_cfg.src);
  assign busy     = (state_q != ST_RUN);

  always_comb begin
    gen_tick = 1'b0;
    load     = 1'b0;
    case (state_q)
      ST_RUN:   gen_tick = old_tick;
      ST_DRAIN: gen_tick = old_tick && out_level;
      ST_SYNC:  load     = new_tick && edge_seen_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      edge_seen_q <= 1'b0;
      act_cfg     <= '0;
      act_m       <= '0;
      act_n       <= '0;
      act_d       <= '0;
    end else begin
      case (state_q)
        ST_RUN: if (upd_req) state_q <= ST_DRAIN;
        ST_DRAIN: begin
          if (!out_level) begin
            state_q     <= ST_SYNC;
            edge_seen_q <= 1'b0;
          end
        end
        ST_SYNC: begin
          if (new_tick) begin
            if (edge_seen_q) begin
              act_cfg <= sh_cfg;
              act_m   <= sh_m;
              act_n   <= sh_n;
              act_d   <= sh_d;
              state_q <= ST_RUN;
            end else begin
              edge_seen_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rcg_predivider.sv
module rcg_predivider #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] act_div,
  input  logic [DIV_W-1:0] nxt_div,
  input  logic             tick,
  input  logic             load,
  output logic             wrap,
  output logic             level
);
  localparam int PC_W = DIV_W + 1;

  // Period in source edges: field 0 is bypass (2 edges), else field+1
  function automatic logic [PC_W-1:0] span(input logic [DIV_W-1:0] f);
    return (f == '0) ? PC_W'(2) : PC_W'(f) + PC_W'(1);
  endfunction

  logic [PC_W-1:0] pc_q, pc_nxt, per;

  always_comb begin
    per    = span(act_div);
    pc_nxt = (pc_q == per - PC_W'(1)) ? '0 : pc_q + PC_W'(1);
    wrap   = (pc_nxt == '0);
    level  = (pc_nxt < (per >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= span('0) - PC_W'(1);
    else if (load) pc_q <= span(nxt_div) - PC_W'(1);
    else if (tick) pc_q <= pc_nxt;
  end
endmodule

// File: rtl/rcg_mnd.sv
module rcg_mnd #(
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MND_W-1:0] m_val,
  input  logic [MND_W-1:0] n_reg,
  input  logic [MND_W-1:0] d_reg,
  input  logic             step,
  input  logic             load,
  output logic             level,
  output logic             n_nonzero
);
  logic [MND_W-1:0] acc_q, n_dec, d_dec;
  logic [MND_W:0]   sum;
  logic             over;

  always_comb begin
    n_dec     = m_val + ~n_reg;
    d_dec     = (~d_reg) >> 1;
    sum       = {1'b0, acc_q} + {1'b0, m_val};
    over      = (sum >= {1'b0, n_dec});
    level     = (acc_q < d_dec);
    n_nonzero = (n_reg != '0);
  end

  always_ff @(posedge clk) begin
    if (rst || load) acc_q <= '0;
    else if (step)   acc_q <= over ? MND_W'(sum - {1'b0, n_dec}) : MND_W'(sum);
  end
endmodule

// File: rtl/rcg_root.sv
module rcg_root
  import rcg_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter int MND_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              upd_busy,
  output logic              clk_out
);
  cfg_t             sh_cfg, act_cfg;
  logic [MND_W-1:0] sh_m, sh_n, sh_d, act_m, act_n, act_d;
  logic             upd_req, gen_tick, load_pulse;
  logic             div_wrap, div_level, frac_level, frac_n_nz, frac_on;

  rcg_regs #(.DATA_W(DATA_W), .MND_W(MND_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(upd_busy), .bus_rdata(bus_rdata),
    .sh_cfg(sh_cfg), .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d), .upd_req(upd_req)
  );

  rcg_switch_ctrl #(.NSRC(NSRC), .MND_W(MND_W)) u_ctrl (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .sh_cfg(sh_cfg), .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d),
    .upd_req(upd_req), .out_level(clk_out),
    .act_cfg(act_cfg), .act_m(act_m), .act_n(act_n), .act_d(act_d),
    .gen_tick(gen_tick), .load(load_pulse), .busy(upd_busy)
  );

  rcg_predivider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .act_div(act_cfg.div), .nxt_div(sh_cfg.div),
    .tick(gen_tick), .load(load_pulse), .wrap(div_wrap), .level(div_level)
  );

  rcg_mnd #(.MND_W(MND_W)) u_mnd (
    .clk(clk), .rst(rst), .m_val(act_m), .n_reg(act_n), .d_reg(act_d),
    .step(gen_tick && div_wrap), .load(load_pulse),
    .level(frac_level), .n_nonzero(frac_n_nz)
  );

  assign frac_on = (act_cfg.mode == MODE_FRAC) && frac_n_nz;

  always_ff @(posedge clk) begin
    if (rst) clk_out <= 1'b0;
    else if (gen_tick) begin
      if (!frac_on)      clk_out <= div_level;
      else if (div_wrap) clk_out <= frac_level;
    end
  end
endmodule

// File: rtl/rcg_root_chk.sv
module rcg_root_chk
  import rcg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_valid,
  input logic                    bus_write,
  input logic [2:0]              bus_addr,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic                    upd_busy,
  input logic                    clk_out,
  input logic                    gen_tick,
  input logic                    load_pulse,
  input logic [$bits(cfg_t)-1:0] act_cfg
);
  AST_UPDATE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == A_CMD && bus_wdata[0] && !upd_busy) |=> upd_busy); // R8

  AST_HANDOVER_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(upd_busy) |-> !clk_out); // R10

  AST_LOAD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> !clk_out); // R10

  AST_QUIET_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !gen_tick |=> $stable(clk_out)); // R2

  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !upd_busy |=> $stable(act_cfg)); // R7

  AST_CMD_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr == A_CMD) |=> (bus_rdata[0] == $past(upd_busy))); // R9
endmodule

bind rcg_root rcg_root_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .upd_busy(upd_busy), .clk_out(clk_out), .gen_tick(gen_tick),
  .load_pulse(load_pulse), .act_cfg(act_cfg)
);

// File: tb/test_rcg_root.sv
module test_rcg_root;
  localparam int NSRC = 4;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_tick = '0;
  logic            bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]      bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            upd_busy, clk_out;

  int checks = 0, failures = 0, cyc = 0;
  bit model_on = 0, done = 0;

  always #4 clk = ~clk;

  rcg_root #(.NSRC(NSRC), .MND_W(8), .DATA_W(DW)) i_rcg_root (
    .clk(clk), .rst(rst), .src_tick(src_tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .upd_busy(upd_busy), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Source i produces an edge strobe every i+1 cycles
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < NSRC; i++) src_tick[i] <= ((cyc + 1) % (i + 1)) == 0;
  end

  // ---------------- behavioural reference model ----------------
  int a_src, a_f, a_mode, a_m, a_n, a_d;
  int s_src, s_f, s_mode, s_m, s_n, s_d;
  int m_pc, m_acc, m_out, m_phase, m_seen;

  function automatic int period_of(input int f);
    return (f == 0) ? 2 : f + 1;
  endfunction

  function automatic bit edge_of(input int idx);
    return (idx < NSRC) ? src_tick[idx] : 1'b0;
  endfunction

  task automatic model_step_edge();
    int p, nn, dd;
    p = period_of(a_f);
    m_pc = (m_pc == p - 1) ? 0 : m_pc + 1;
    if (a_mode == 2 && a_n != 0) begin
      nn = (a_m + ((~a_n) & 255)) & 255;
      dd = ((~a_d) & 255) >> 1;
      if (m_pc == 0) begin
        m_out = (m_acc < dd);
        m_acc = m_acc + a_m;
        if (m_acc >= nn) m_acc = m_acc - nn;
      end
    end else begin
      m_out = (m_pc < p / 2);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      a_src = 0; a_f = 0; a_mode = 0; a_m = 0; a_n = 0; a_d = 0;
      s_src = 0; s_f = 0; s_mode = 0; s_m = 0; s_n = 0; s_d = 0;
      m_pc = 1; m_acc = 0; m_out = 0; m_phase = 0; m_seen = 0;
    end else begin
      int start_phase;
      start_phase = m_phase;
      if (m_phase == 0) begin
        if (edge_of(a_src)) model_step_edge();
      end else if (m_phase == 1) begin
        if (m_out == 0) begin m_phase = 2; m_seen = 0; end
        else if (edge_of(a_src)) model_step_edge();
      end else begin
        if (edge_of(s_src)) begin
          if (m_seen) begin
            a_src = s_src; a_f = s_f; a_mode = s_mode;
            a_m = s_m; a_n = s_n; a_d = s_d;
            m_pc = period_of(a_f) - 1; m_acc = 0; m_phase = 0;
          end else m_seen = 1;
        end
      end
      if (bus_valid && bus_write) begin
        case (bus_addr)
          3'd0: if (bus_wdata[0] && start_phase == 0) m_phase = 1;
          3'd1: begin
            s_src = int'(bus_wdata[10:8]); s_mode = int'(bus_wdata[13:12]);
            s_f = int'(bus_wdata[4:0]);
          end
          3'd2: s_m = int'(bus_wdata[7:0]);
          3'd3: s_n = int'(bus_wdata[7:0]);
          3'd4: s_d = int'(bus_wdata[7:0]);
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model, plus handover check
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (model_on && !done) begin
      check(clk_out === m_out[0], "R2 clk_out vs model", int'(clk_out), m_out);
      check(upd_busy === (m_phase != 0), "R8 upd_busy vs model", int'(upd_busy), int'(m_phase != 0));
      if (prev_busy && !upd_busy)
        check(clk_out == 1'b0, "R10 busy fell with output low", int'(clk_out), 0);
    end
    prev_busy <= upd_busy;
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [DW-1:0] cfg_word(input int src, input int mode, input int f);
    return DW'((mode << 12) | (src << 8) | f);
  endfunction

  task automatic apply_update();
    logic [DW-1:0] d;
    int polls;
    bus_wr(3'd0, 1);
    bus_rd(3'd0, d);
    check(d[0] == 1'b1, "R8 busy reads 1 after command", int'(d[0]), 1);
    polls = 0;
    while (d[0] && polls < 100) begin
      bus_rd(3'd0, d);
      polls++;
    end
    check(d[0] == 1'b0, "R8 busy self-clears within bound", int'(d[0]), 0);
  endtask

  task automatic measure(output int hi, output int per);
    while (clk_out)  @(negedge clk);
    while (!clk_out) @(negedge clk);
    hi = 0;
    while (clk_out)  begin hi++; @(negedge clk); end
    per = hi;
    while (!clk_out) begin per++; @(negedge clk); end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int hi, per;
    repeat (4) @(negedge clk);
    check(clk_out == 1'b0, "R1 clk_out low in reset", int'(clk_out), 0);
    check(upd_busy == 1'b0, "R1 busy low in reset", int'(upd_busy), 0);
    rst = 1'b0;
    model_on = 1;
    for (int a = 0; a < 5; a++) begin
      bus_rd(3'(a), d);
      check(d == '0, "R1 register reset value", int'(d), 0);
    end

    // R3 / R1: default source 0, bypass divider
    measure(hi, per);
    check(per == 2, "R3 bypass period", per, 2);
    check(hi == 1, "R3 bypass high time", hi, 1);

    // R7: shadow write without update; R9 readback; R11 source 1
    bus_wr(3'd1, cfg_word(1, 0, 5));
    repeat (6) @(negedge clk);
    measure(hi, per);
    check(per == 2, "R7 period unchanged before update", per, 2);
    bus_rd(3'd1, d);
    check(d == cfg_word(1, 0, 5), "R9 cfg readback", int'(d), int'(cfg_word(1, 0, 5)));
    apply_update();
    measure(hi, per);
    check(per == 12, "R2 integer divide by 3 on source 1 (R11)", per, 12);
    check(hi == 6, "R2 integer divide high time", hi, 6);

    // R2 half-integer: field 4 -> divide by 2.5
    bus_wr(3'd1, cfg_word(0, 0, 4));
    apply_update();
    measure(hi, per);
    check(per == 5, "R2 half-integer period", per, 5);
    check(hi == 2, "R2 half-integer high time", hi, 2);

    // R5: M=1, N=5, D=2
    bus_wr(3'd2, 1);
    bus_wr(3'd3, 32'hFB);
    bus_wr(3'd4, 32'hFB);
    bus_wr(3'd1, cfg_word(0, 2, 0));
    bus_rd(3'd3, d);
    check(d == 32'hFB, "R9 N register readback", int'(d), 32'hFB);
    apply_update();
    measure(hi, per);
    check(per == 10, "R5 fractional period", per, 10);
    check(hi == 4, "R5 fractional high time", hi, 4);

    // R4: mode 1 bypasses the fractional stage
    bus_wr(3'd1, cfg_word(0, 1, 0));
    apply_update();
    measure(hi, per);
    check(per == 2, "R4 mode 1 bypass period", per, 2);
    check(hi == 1, "R4 mode 1 bypass high", hi, 1);

    // R6: mode 2 with N register 0 bypasses
    bus_wr(3'd3, 0);
    bus_wr(3'd1, cfg_word(0, 2, 2));
    apply_update();
    measure(hi, per);
    check(per == 3, "R6 zero N register bypass period", per, 3);
    check(hi == 1, "R6 zero N register bypass high", hi, 1);

    // R5: M=2, N=5, D=2 on slow source 2, checked cycle by cycle by the model
    bus_wr(3'd2, 2);
    bus_wr(3'd3, 32'hFC);
    bus_wr(3'd1, cfg_word(2, 2, 1));
    apply_update();
    repeat (120) @(negedge clk);

    // R9: unused bits read 0, unmapped address reads 0
    bus_wr(3'd1, 32'hFFFF_FFFF);
    bus_rd(3'd1, d);
    check(d == 32'h371F, "R9 cfg writable bits only", int'(d), 32'h371F);
    bus_rd(3'd7, d);
    check(d == '0, "R9 unmapped address", int'(d), 0);
    repeat (20) @(negedge clk);
    bus_wr(3'd1, cfg_word(3, 0, 1));
    apply_update();
    measure(hi, per);
    check(per == 8, "R11 source 3 divide by 1", per, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule